// File: doc/BRIEF.md
# Character Border and Shadow Generator

This block turns the font bit-rows of one on-screen-display character line into a stream of dots for a colour encoder. Three parallel line shift registers hold the glyph row being drawn together with the rows directly above and below it. From these, the block can see all four direct neighbours of the dot it is emitting. It reports each dot either as foreground luminance or as a black edge. Font lookup and colour encoding happen outside the block.

A dot-load strobe captures the three rows and restarts serialization at the leftmost column. The block then emits one dot per pixel clock, most significant bit first. A line-advance strobe steps an internal row index through the rows of the cell. At the top row of a cell the row above is ignored, and at the bottom row the row below is ignored, so edges never take context from a neighbouring character. Two mode inputs select the edge style:
- No edge.
- A four-sided outline.
- A right/bottom drop shadow.

Top module: `char_edge_gen`

## Requirements
- R1: After reset both outputs are 0, the row index is 0 and the serializer is idle, so no dot is emitted until a load.
- R2: A dot_load sampled high at a rising edge captures row_above, row_cur and row_below. Column k of the cell (k = 0 is bit CELL_W-1 of the row, counting down to bit 0) is presented on the outputs just after the (k+1)-th rising edge following that load edge, for k = 0 to CELL_W-1. This gives a fixed one-clock register latency.
- R3: With bord_en = 1 and shadow_sel = 0, edge_o is 1 for an unlit dot whose left, right, upper or lower neighbour is lit. Diagonal neighbours do not count.
- R4: With bord_en = 1 and shadow_sel = 1, edge_o is 1 only for an unlit dot whose left neighbour or upper neighbour is lit. The edge therefore falls to the right of and below the glyph.
- R5: With bord_en = 0, edge_o stays 0 and lum_o equals the glyph dot, whatever shadow_sel is.
- R6: A lit dot drives lum_o = 1 and is never reported as an edge. lum_o and edge_o are never both 1.
- R7: Positions outside the cell count as unlit. Column 0 has no lit left neighbour and column CELL_W-1 has no lit right neighbour. Once the last column has been emitted, both outputs are 0 until the next load.
- R8: Each line_adv pulse advances the row index by one, wrapping from CELL_H-1 to 0. The index in force at the load edge is used, before any advance in the same cycle. Row_above is treated as all zero at index 0, and row_below is treated as all zero at index CELL_H-1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| dot_load | input | 1 | Capture the three rows and start at column 0 |
| line_adv | input | 1 | Advance the row index within the cell |
| bord_en | input | 1 | Enable edge generation |
| shadow_sel | input | 1 | 1 selects drop shadow, 0 selects four-sided outline |
| row_above | input | CELL_W | Font row of the line above |
| row_cur | input | CELL_W | Font row of the line being drawn |
| row_below | input | CELL_W | Font row of the line below |
| lum_o | output | 1 | Foreground dot |
| edge_o | output | 1 | Black edge dot |

## Verification
Every row of five glyphs is swept in all three modes. An isolated single dot shows the exact four-sided shape against the two-sided shadow and confirms that diagonals stay clear. A hollow box puts inner and outer edges next to lit strokes, and a checkerboard, where every unlit dot has lit side neighbours, separates the modes on every position. A glyph that is solid along the top and bottom rows and on both side columns, driven with all-ones garbage beyond the cell, tells correct row-index masking and cell-edge clipping apart from leakage. A scrambled pattern covers irregular mixes.

// File: rtl/ceg_pkg.sv
package ceg_pkg;
    typedef enum logic [1:0] {
        EM_OFF    = 2'd0,
        EM_BORDER = 2'd1,
        EM_SHADOW = 2'd2
    } edge_mode_e;
endpackage

// File: rtl/ceg_line_sreg.sv
module ceg_line_sreg #(
    parameter int W = 12
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] din,
    output logic         left_o,
    output logic         cur_o,
    output logic         right_o
);
    // bit W holds the dot already shifted past (left neighbour)
    logic [W:0] sr_d, sr_q;

    always_comb begin
        if (load) sr_d = {1'b0, din};
        else      sr_d = {sr_q[W-1:0], 1'b0};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sr_q <= '0;
        else        sr_q <= sr_d;
    end

    assign left_o  = sr_q[W];
    assign cur_o   = sr_q[W-1];
    assign right_o = sr_q[W-2];
endmodule

// File: rtl/ceg_edge_logic.sv
module ceg_edge_logic
    import ceg_pkg::*;
(
    input  edge_mode_e mode,
    input  logic       in_cell,
    input  logic       left_i,
    input  logic       cur_i,
    input  logic       right_i,
    input  logic       up_i,
    input  logic       down_i,
    output logic       lum_o,
    output logic       edg_o
);
    logic touch;

    always_comb begin
        unique case (mode)
            EM_BORDER: touch = left_i | right_i | up_i | down_i;
            EM_SHADOW: touch = left_i | up_i;
            default:   touch = 1'b0;
        endcase
        lum_o = in_cell & cur_i;
        edg_o = in_cell & ~cur_i & touch;
    end
endmodule

// File: rtl/char_edge_gen.sv
module char_edge_gen
    import ceg_pkg::*;
#(
    parameter int CELL_W = 12,
    parameter int CELL_H = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              dot_load,
    input  logic              line_adv,
    input  logic              bord_en,
    input  logic              shadow_sel,
    input  logic [CELL_W-1:0] row_above,
    input  logic [CELL_W-1:0] row_cur,
    input  logic [CELL_W-1:0] row_below,
    output logic              lum_o,
    output logic              edge_o
);
    localparam int POS_W = $clog2(CELL_W + 1);
    localparam int ROW_W = $clog2(CELL_H);
    localparam int NLANE = 3;
    localparam logic [POS_W-1:0] POS_IDLE = POS_W'(CELL_W);
    localparam logic [ROW_W-1:0] ROW_LAST = ROW_W'(CELL_H - 1);

    typedef struct packed {
        logic [POS_W-1:0] pos;
        logic [ROW_W-1:0] row;
        logic             lum;
        logic             edg;
    } state_t;

    state_t st_d, st_q;

    logic [CELL_W-1:0] lane_din [NLANE];
    logic [NLANE-1:0]  lane_l, lane_c, lane_r;
    logic              comb_lum, comb_edg;
    edge_mode_e        mode;

    // lane 0 = above, 1 = current, 2 = below; boundary rows are masked
    always_comb begin
        lane_din[0] = (st_q.row == '0)      ? '0 : row_above;
        lane_din[1] = row_cur;
        lane_din[2] = (st_q.row == ROW_LAST) ? '0 : row_below;
    end

    for (genvar i = 0; i < NLANE; i++) begin : g_lane
        ceg_line_sreg #(.W(CELL_W)) u_lane (
            .clk     (clk),
            .rst_n   (rst_n),
            .load    (dot_load),
            .din     (lane_din[i]),
            .left_o  (lane_l[i]),
            .cur_o   (lane_c[i]),
            .right_o (lane_r[i])
        );
    end

    always_comb begin
        if (!bord_en)       mode = EM_OFF;
        else if (shadow_sel) mode = EM_SHADOW;
        else                mode = EM_BORDER;
    end

    ceg_edge_logic u_edge (
        .mode    (mode),
        .in_cell (st_q.pos != POS_IDLE),
        .left_i  (lane_l[1]),
        .cur_i   (lane_c[1]),
        .right_i (lane_r[1]),
        .up_i    (lane_c[0]),
        .down_i  (lane_c[2]),
        .lum_o   (comb_lum),
        .edg_o   (comb_edg)
    );

    always_comb begin
        st_d     = st_q;
        st_d.lum = comb_lum;
        st_d.edg = comb_edg;
        if (dot_load)                st_d.pos = '0;
        else if (st_q.pos != POS_IDLE) st_d.pos = st_q.pos + 1'b1;
        if (line_adv)
            st_d.row = (st_q.row == ROW_LAST) ? '0 : st_q.row + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.pos <= POS_IDLE;
            st_q.row <= '0;
            st_q.lum <= 1'b0;
            st_q.edg <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign lum_o  = st_q.lum;
    assign edge_o = st_q.edg;

    logic [POS_W-1:0] pos_q;
    logic [ROW_W-1:0] row_q;
    assign pos_q = st_q.pos;
    assign row_q = st_q.row;
endmodule

// File: rtl/ceg_checker.sv
module ceg_checker #(
    parameter int CELL_W = 12,
    parameter int CELL_H = 16
) (
    input logic                         clk,
    input logic                         rst_n,
    input logic                         dot_load,
    input logic                         line_adv,
    input logic                         bord_en,
    input logic                         lum_o,
    input logic                         edge_o,
    input logic [$clog2(CELL_W+1)-1:0]  pos_q,
    input logic [$clog2(CELL_H)-1:0]    row_q
);
    localparam int POS_W = $clog2(CELL_W + 1);
    localparam int ROW_W = $clog2(CELL_H);

    assert_lum_over_edge_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !(lum_o && edge_o));

    assert_no_edge_when_off_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !bord_en |=> !edge_o);

    assert_quiet_outside_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (pos_q == POS_W'(CELL_W)) |=> (!lum_o && !edge_o));

    assert_load_restart_R2: assert property (@(posedge clk) disable iff (!rst_n)
        dot_load |=> (pos_q == '0));

    assert_row_wrap_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (line_adv && row_q == ROW_W'(CELL_H - 1)) |=> (row_q == '0));

    assert_row_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !line_adv |=> $stable(row_q));
endmodule

bind char_edge_gen ceg_checker #(.CELL_W(CELL_W), .CELL_H(CELL_H)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .dot_load (dot_load),
    .line_adv (line_adv),
    .bord_en  (bord_en),
    .lum_o    (lum_o),
    .edge_o   (edge_o),
    .pos_q    (pos_q),
    .row_q    (row_q)
);

// File: tb/sim_char_edge_gen.sv
`timescale 1ns/1ps
module sim_char_edge_gen;
    localparam int W = 12;
    localparam int H = 16;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic dot_load = 1'b0, line_adv = 1'b0, bord_en = 1'b0, shadow_sel = 1'b0;
    logic [W-1:0] row_above = '0, row_cur = '0, row_below = '0;
    logic lum_o, edge_o;

    int n_chk = 0;
    int n_bad = 0;
    logic [W-1:0] g [H];

    always #4 clk = ~clk;

    char_edge_gen #(.CELL_W(W), .CELL_H(H)) u0 (
        .clk(clk), .rst_n(rst_n), .dot_load(dot_load), .line_adv(line_adv),
        .bord_en(bord_en), .shadow_sel(shadow_sel), .row_above(row_above),
        .row_cur(row_cur), .row_below(row_below), .lum_o(lum_o), .edge_o(edge_o)
    );

    task automatic check(string req, logic [1:0] act, logic [1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: {lum,edge} actual %b expected %b", req, act, exp);
        end
    endtask

    function automatic bit gb(int r, int c);
        if (r < 0 || r >= H || c < 0 || c >= W) return 1'b0;
        return g[r][W-1-c];
    endfunction

    function automatic void fill(int p);
        for (int r = 0; r < H; r++) begin
            case (p)
                0: g[r] = (r == 5) ? 12'h020 : 12'h000;
                1: g[r] = (r == 2 || r == 13) ? 12'h7FE :
                          ((r > 2 && r < 13) ? 12'h402 : 12'h000);
                2: g[r] = r[0] ? 12'hAAA : 12'h555;
                3: g[r] = (r == 0 || r == H-1) ? 12'hFFF : 12'h801;
                default: g[r] = 12'(r * 12'h2B5) ^ 12'h3C1;
            endcase
        end
    endfunction

    task automatic run_glyph(int mode);
        for (int r = 0; r < H; r++) begin
            string tag;
            row_cur   = g[r];
            row_above = (r == 0)   ? '1 : g[r-1];
            row_below = (r == H-1) ? '1 : g[r+1];
            dot_load  = 1'b1;
            @(negedge clk);
            dot_load  = 1'b0;
            for (int k = 0; k < W; k++) begin
                bit cur, l, rt, u, d, e;
                @(negedge clk);
                cur = gb(r, k); l = gb(r, k-1); rt = gb(r, k+1);
                u = gb(r-1, k); d = gb(r+1, k);
                case (mode)
                    1: begin e = !cur && (l || rt || u || d); tag = "R2 R3"; end
                    2: begin e = !cur && (l || u);            tag = "R2 R4"; end
                    default: begin e = 1'b0;                  tag = "R2 R5"; end
                endcase
                if (r == 0 || r == H-1) tag = {tag, " R8"};
                if (k == 0 || k == W-1) tag = {tag, " R7"};
                check(tag, {lum_o, edge_o}, {cur, e});
                check("R6", {1'b0, lum_o && edge_o}, 2'b00);
            end
            line_adv = 1'b1;
            @(negedge clk);
            line_adv = 1'b0;
            check("R7 idle after last column", {lum_o, edge_o}, 2'b00);
        end
    endtask

    initial begin
        #(8 * 200000);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R1 reset outputs", {lum_o, edge_o}, 2'b00);
        rst_n = 1'b1;
        bord_en = 1'b1;
        row_cur = '1;
        repeat (3) @(negedge clk);
        check("R1 idle without load", {lum_o, edge_o}, 2'b00);
        for (int p = 0; p < 5; p++) begin
            fill(p);
            for (int m = 0; m < 4; m++) begin
                bord_en    = (m == 1 || m == 2);
                shadow_sel = (m == 2 || m == 3);
                run_glyph(m == 3 ? 0 : m);
            end
        end
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule